// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core with seven operating modes. A 5-bit mode input picks which physical copy of each general register and which saved status register the ports see. The fast-interrupt mode has private copies of r8 to r14. The interrupt, supervisor, abort and undefined modes each have private copies of r13 and r14 only. User and system modes share one set. The storage holds 30 general registers, the program counter, the current status register and five saved status registers, which makes 37 words in all.

Two combinational read ports and one clocked write port serve the general registers. The program counter has its own raw read port and its own write port. When r15 is read as an operand, the port returns the program counter plus a fixed pipeline offset. A user-bank select input lets a privileged mode reach the user copies of the banked registers. Instruction decode and exception sequencing stay outside this block. They drive the mode input and the user-bank select input.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register reads zero: general reads return 0, `pc_o`, `cpsr_o` and `spsr_o` are 0, and an r15 operand read returns the offset (8).
- R2: Mode codes are user 10000, fast interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. System mode and any unlisted code use the user register set.
- R3: In fast-interrupt mode, r8 to r14 are private copies. r0 to r7 are shared with user mode.
- R4: Interrupt, supervisor, abort and undefined modes each have private r13 and r14. Their r0 to r12 are the user copies.
- R5: Both read ports are combinational and independent of each other. A write lands on the rising edge, so a read of the register being written in that cycle returns the old value.
- R6: A read of address 15 on either read port returns `pc_o` plus 8, modulo 2^32.
- R7: `pc_o` shows the raw program counter, and `pc_wr_en_i` loads it. A general write to address 15 also loads the program counter, and it takes priority over the program-counter port in the same cycle.
- R8: With `user_bank_i` high, reads and writes of r8 to r14 on the general ports reach the user copies, whatever the mode.
- R9: Each of fast interrupt, interrupt, supervisor, abort and undefined has its own saved status register on `spsr_o` and `spsr_wr_en_i`. In user, system and unlisted modes, `spsr_o` reads 0 and saved-status writes change nothing.
- R10: `cpsr_wr_en_i` loads the current status register on the edge, and `cpsr_o` shows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Current operating mode |
| user_bank_i | input | 1 | Steer general ports to user copies |
| rd_a_addr_i | input | 4 | Read port A register number |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_addr_i | input | 4 | Read port B register number |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | General write enable |
| wr_addr_i | input | 4 | General write register number |
| wr_data_i | input | 32 | General write data |
| pc_wr_en_i | input | 1 | Program counter write enable |
| pc_wr_data_i | input | 32 | Program counter write data |
| pc_o | output | 32 | Raw program counter |
| cpsr_wr_en_i | input | 1 | Current status write enable |
| cpsr_wr_data_i | input | 32 | Current status write data |
| cpsr_o | output | 32 | Current status register |
| spsr_wr_en_i | input | 1 | Saved status write enable (current mode) |
| spsr_wr_data_i | input | 32 | Saved status write data |
| spsr_o | output | 32 | Saved status register of current mode |

## Verification
The bench builds the block with its defaults: 32-bit data and an r15 read offset of 8. Every bank is given a distinct marker value and then read back from every mode. This shows that each physical copy is reached only from the intended modes, and that user-bank select and unlisted codes fall through to the user set. A full 32-bit word also makes the offset wrap from 0xFFFFFFFC to 4 reachable. Same-edge cases are checked directly: a write against a read of the same register, and a general write to r15 against a program-counter port write.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;
  localparam int ARCH_W     = 4;
  localparam int NUM_GP     = 30;
  localparam int GP_IDX_W   = $clog2(NUM_GP);
  localparam int NUM_SPSR   = 5;
  localparam int SPSR_IDX_W = $clog2(NUM_SPSR);
  localparam int FIQ_FIRST  = 8;
  localparam int FIQ_BASE   = 15;
  localparam int SHORT_FIRST = 13;
  localparam int SHORT_BASE = 22;
  localparam logic [ARCH_W-1:0] PC_ADDR = 4'd15;

  typedef enum logic [4:0] {
    MODE_USR = 5'b10000,
    MODE_FIQ = 5'b10001,
    MODE_IRQ = 5'b10010,
    MODE_SVC = 5'b10011,
    MODE_ABT = 5'b10111,
    MODE_UND = 5'b11011,
    MODE_SYS = 5'b11111
  } mode_e;

  // slot among modes banking only r13/r14; 7 = none
  function automatic logic [2:0] short_slot(input logic [4:0] m);
    case (m)
      MODE_IRQ: return 3'd0;
      MODE_SVC: return 3'd1;
      MODE_ABT: return 3'd2;
      MODE_UND: return 3'd3;
      default:  return 3'd7;
    endcase
  endfunction

  function automatic logic [GP_IDX_W-1:0] gp_index(input logic [4:0] m, input logic ub,
                                                   input logic [ARCH_W-1:0] a);
    logic [2:0] s;
    logic [GP_IDX_W-1:0] r;
    s = short_slot(m);
    r = GP_IDX_W'(a);
    if (!ub && a != PC_ADDR) begin
      if (m == MODE_FIQ && a >= ARCH_W'(FIQ_FIRST))
        r = GP_IDX_W'(FIQ_BASE - FIQ_FIRST) + GP_IDX_W'(a);
      else if (s != 3'd7 && a >= ARCH_W'(SHORT_FIRST))
        r = GP_IDX_W'(SHORT_BASE - SHORT_FIRST) + GP_IDX_W'({s, 1'b0}) + GP_IDX_W'(a);
    end
    return r;
  endfunction

  function automatic logic [SPSR_IDX_W:0] spsr_slot(input logic [4:0] m);
    case (m)
      MODE_FIQ: return {1'b1, SPSR_IDX_W'(0)};
      MODE_IRQ: return {1'b1, SPSR_IDX_W'(1)};
      MODE_SVC: return {1'b1, SPSR_IDX_W'(2)};
      MODE_ABT: return {1'b1, SPSR_IDX_W'(3)};
      MODE_UND: return {1'b1, SPSR_IDX_W'(4)};
      default:  return '0;
    endcase
  endfunction
endpackage

// File: rtl/banked_rf_map.sv
module banked_rf_map
  import banked_rf_pkg::*;
(
  input  logic [4:0]          mode_i,
  input  logic                user_bank_i,
  input  logic [ARCH_W-1:0]   addr_i,
  output logic [GP_IDX_W-1:0] idx_o,
  output logic                is_pc_o
);
  always_comb begin
    idx_o   = gp_index(mode_i, user_bank_i, addr_i);
    is_pc_o = (addr_i == PC_ADDR);
  end
endmodule

// File: rtl/banked_rf_gpr.sv
module banked_rf_gpr
  import banked_rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [GP_IDX_W-1:0] rd_a_idx_i,
  input  logic                rd_a_pc_i,
  output logic [DATA_W-1:0]   rd_a_data_o,
  input  logic [GP_IDX_W-1:0] rd_b_idx_i,
  input  logic                rd_b_pc_i,
  output logic [DATA_W-1:0]   rd_b_data_o,
  input  logic                wr_en_i,
  input  logic [GP_IDX_W-1:0] wr_idx_i,
  input  logic                wr_pc_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                pc_wr_en_i,
  input  logic [DATA_W-1:0]   pc_wr_data_i,
  output logic [DATA_W-1:0]   pc_o
);
  localparam logic [DATA_W-1:0] PC_ADD = DATA_W'(PC_OFFSET);

  logic [NUM_GP-1:0][DATA_W-1:0] regs_q;
  logic [NUM_GP-1:0]             gp_we;
  logic [DATA_W-1:0]             pc_q;
  logic [DATA_W-1:0]             pc_rd;

  assign pc_rd = pc_q + PC_ADD;
  assign pc_o  = pc_q;

  for (genvar i = 0; i < NUM_GP; i++) begin : g_reg
    assign gp_we[i] = wr_en_i && !wr_pc_i && (wr_idx_i == GP_IDX_W'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       regs_q[i] <= '0;
      else if (gp_we[i]) regs_q[i] <= wr_data_i;
    end
    // R5
    reg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !gp_we[i] |=> $stable(regs_q[i]));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 pc_q <= '0;
    else if (wr_en_i && wr_pc_i) pc_q <= wr_data_i;
    else if (pc_wr_en_i)         pc_q <= pc_wr_data_i;
  end

  always_comb begin
    rd_a_data_o = rd_a_pc_i ? pc_rd : regs_q[rd_a_idx_i];
    rd_b_data_o = rd_b_pc_i ? pc_rd : regs_q[rd_b_idx_i];
  end

  // R5
  gp_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_pc_i) |=> regs_q[$past(wr_idx_i)] == $past(wr_data_i));
  // R7
  pc_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_pc_i) |=> pc_q == $past(wr_data_i));
  // R7
  pc_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_en_i && !(wr_en_i && wr_pc_i)) |=> pc_q == $past(pc_wr_data_i));
  // R5
  one_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(gp_we));
endmodule

// File: rtl/banked_rf_psr.sv
module banked_rf_psr
  import banked_rf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              cpsr_wr_en_i,
  input  logic [DATA_W-1:0] cpsr_wr_data_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_wr_en_i,
  input  logic [DATA_W-1:0] spsr_wr_data_i,
  output logic [DATA_W-1:0] spsr_o
);
  logic [NUM_SPSR-1:0][DATA_W-1:0] spsr_q;
  logic [DATA_W-1:0]               cpsr_q;
  logic [SPSR_IDX_W:0]             slot;
  logic                            slot_vld;
  logic [SPSR_IDX_W-1:0]           slot_idx;

  assign slot     = spsr_slot(mode_i);
  assign slot_vld = slot[SPSR_IDX_W];
  assign slot_idx = slot[SPSR_IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cpsr_q <= '0;
    else if (cpsr_wr_en_i) cpsr_q <= cpsr_wr_data_i;
  end

  for (genvar i = 0; i < NUM_SPSR; i++) begin : g_spsr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        spsr_q[i] <= '0;
      else if (spsr_wr_en_i && slot_vld && slot_idx == SPSR_IDX_W'(i))
        spsr_q[i] <= spsr_wr_data_i;
    end
  end

  assign cpsr_o = cpsr_q;
  assign spsr_o = slot_vld ? spsr_q[slot_idx] : '0;

  // R9
  spsr_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spsr_wr_en_i && !slot_vld) |=> $stable(spsr_q));
  // R10
  cpsr_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpsr_wr_en_i |=> cpsr_q == $past(cpsr_wr_data_i));
  // R9
  spsr_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_vld |-> spsr_o == '0);
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int PC_OFFSET = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              user_bank_i,
  input  logic [3:0]        rd_a_addr_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_addr_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pc_wr_en_i,
  input  logic [DATA_W-1:0] pc_wr_data_i,
  output logic [DATA_W-1:0] pc_o,
  input  logic              cpsr_wr_en_i,
  input  logic [DATA_W-1:0] cpsr_wr_data_i,
  output logic [DATA_W-1:0] cpsr_o,
  input  logic              spsr_wr_en_i,
  input  logic [DATA_W-1:0] spsr_wr_data_i,
  output logic [DATA_W-1:0] spsr_o
);
  localparam int NUM_PORTS = 3;  // read A, read B, write

  logic [NUM_PORTS-1:0][3:0]          port_addr;
  logic [NUM_PORTS-1:0][GP_IDX_W-1:0] port_idx;
  logic [NUM_PORTS-1:0]               port_pc;

  assign port_addr = {wr_addr_i, rd_b_addr_i, rd_a_addr_i};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    banked_rf_map u_map (
      .mode_i      (mode_i),
      .user_bank_i (user_bank_i),
      .addr_i      (port_addr[p]),
      .idx_o       (port_idx[p]),
      .is_pc_o     (port_pc[p])
    );
  end

  banked_rf_gpr #(.DATA_W(DATA_W), .PC_OFFSET(PC_OFFSET)) u_gpr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_a_idx_i   (port_idx[0]),
    .rd_a_pc_i    (port_pc[0]),
    .rd_a_data_o  (rd_a_data_o),
    .rd_b_idx_i   (port_idx[1]),
    .rd_b_pc_i    (port_pc[1]),
    .rd_b_data_o  (rd_b_data_o),
    .wr_en_i      (wr_en_i),
    .wr_idx_i     (port_idx[2]),
    .wr_pc_i      (port_pc[2]),
    .wr_data_i    (wr_data_i),
    .pc_wr_en_i   (pc_wr_en_i),
    .pc_wr_data_i (pc_wr_data_i),
    .pc_o         (pc_o)
  );

  banked_rf_psr #(.DATA_W(DATA_W)) u_psr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .mode_i         (mode_i),
    .cpsr_wr_en_i   (cpsr_wr_en_i),
    .cpsr_wr_data_i (cpsr_wr_data_i),
    .cpsr_o         (cpsr_o),
    .spsr_wr_en_i   (spsr_wr_en_i),
    .spsr_wr_data_i (spsr_wr_data_i),
    .spsr_o         (spsr_o)
  );

  // R6
  pc_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_wr_en_i && !wr_en_i) |=> (rd_a_addr_i != 4'd15) ||
      rd_a_data_o == $past(pc_wr_data_i) + DATA_W'(PC_OFFSET));
endmodule

// File: tb/banked_regfile_test.sv
module banked_regfile_test;
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011,
                         M_SYS = 5'b11111, M_BAD = 5'b00000;

  logic clk = 0, rst_ni = 0;
  logic [4:0] mode = M_USR;
  logic ub = 0;
  logic [3:0] ra = 0, rb = 0, wa = 0;
  logic [31:0] rda, rdb, wd = 0, pcwd = 0, pc, cwd = 0, cpsr, swd = 0, spsr;
  logic we = 0, pcwe = 0, cwe = 0, swe = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  banked_regfile uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .user_bank_i(ub),
    .rd_a_addr_i(ra), .rd_a_data_o(rda), .rd_b_addr_i(rb), .rd_b_data_o(rdb),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .pc_wr_en_i(pcwe), .pc_wr_data_i(pcwd), .pc_o(pc),
    .cpsr_wr_en_i(cwe), .cpsr_wr_data_i(cwd), .cpsr_o(cpsr),
    .spsr_wr_en_i(swe), .spsr_wr_data_i(swd), .spsr_o(spsr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic gw(logic [4:0] m, logic u, logic [3:0] a, logic [31:0] d);
    @(negedge clk); mode = m; ub = u; wa = a; wd = d; we = 1;
    @(negedge clk); we = 0; ub = 0;
  endtask

  task automatic rd(logic [4:0] m, logic u, logic [3:0] a, output logic [31:0] d);
    @(negedge clk); mode = m; ub = u; ra = a; #1 d = rda; ub = 0;
  endtask

  task automatic sw(logic [4:0] m, logic [31:0] d);
    @(negedge clk); mode = m; swd = d; swe = 1;
    @(negedge clk); swe = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(M_USR, 0, 4'd0, v);  chk("R1 r0", v, 0);
    rd(M_FIQ, 0, 4'd14, v); chk("R1 fiq r14", v, 0);
    rd(M_USR, 0, 4'd15, v); chk("R1 r15 read", v, 32'd8);
    chk("R1 pc", pc, 0);
    chk("R1 cpsr", cpsr, 0);
    mode = M_SVC; #1 chk("R1 spsr", spsr, 0);
  endtask

  task automatic t_user_sys;
    logic [31:0] v;
    gw(M_USR, 0, 4'd13, 32'hA0A0_0013);
    rd(M_SYS, 0, 4'd13, v); chk("R2 system shares user r13", v, 32'hA0A0_0013);
    gw(M_BAD, 0, 4'd14, 32'hBAD0_0014);
    rd(M_USR, 0, 4'd14, v); chk("R2 unlisted mode hits user r14", v, 32'hBAD0_0014);
    rd(M_IRQ, 0, 4'd14, v); chk("R2 irq r14 untouched", v, 0);
  endtask

  task automatic t_fiq;
    logic [31:0] v;
    for (int i = 8; i < 15; i++) gw(M_USR, 0, 4'(i), 32'h100 + i);
    for (int i = 8; i < 15; i++) gw(M_FIQ, 0, 4'(i), 32'h200 + i);
    for (int i = 8; i < 15; i++) begin
      rd(M_FIQ, 0, 4'(i), v); chk("R3 fiq private", v, 32'h200 + i);
      rd(M_USR, 0, 4'(i), v); chk("R3 user kept", v, 32'h100 + i);
    end
    gw(M_FIQ, 0, 4'd7, 32'h7777);
    rd(M_USR, 0, 4'd7, v); chk("R3 r7 shared", v, 32'h7777);
  endtask

  task automatic t_short;
    logic [4:0] ms[4] = '{M_IRQ, M_SVC, M_ABT, M_UND};
    logic [31:0] v;
    for (int k = 0; k < 4; k++) begin
      gw(ms[k], 0, 4'd13, 32'h1300 + k);
      gw(ms[k], 0, 4'd14, 32'h1400 + k);
    end
    for (int k = 0; k < 4; k++) begin
      rd(ms[k], 0, 4'd13, v); chk("R4 private r13", v, 32'h1300 + k);
      rd(ms[k], 0, 4'd14, v); chk("R4 private r14", v, 32'h1400 + k);
      rd(ms[k], 0, 4'd12, v); chk("R4 r12 shared", v, 32'h10C);
    end
    rd(M_USR, 0, 4'd13, v); chk("R4 user r13 kept", v, 32'h10D);
    rd(M_FIQ, 0, 4'd13, v); chk("R4 fiq r13 kept", v, 32'h20D);
  endtask

  task automatic t_ports;
    @(negedge clk); mode = M_USR; ra = 4'd7; rb = 4'd12; wa = 4'd7; wd = 32'hC0DE; we = 1;
    #1 chk("R5 old value same cycle", rda, 32'h7777);
    chk("R5 port b independent", rdb, 32'h10C);
    @(negedge clk); we = 0;
    #1 chk("R5 new value after edge", rda, 32'hC0DE);
  endtask

  task automatic t_pc;
    @(negedge clk); pcwd = 32'h1000; pcwe = 1;
    @(negedge clk); pcwe = 0; rb = 4'd15;
    #1 chk("R7 pc raw", pc, 32'h1000);
    chk("R6 r15 on port b", rdb, 32'h1008);
    @(negedge clk); wa = 4'd15; wd = 32'h2000; we = 1; pcwd = 32'h3000; pcwe = 1;
    @(negedge clk); we = 0; pcwe = 0;
    #1 chk("R7 general write wins", pc, 32'h2000);
    @(negedge clk); pcwd = 32'hFFFF_FFFC; pcwe = 1;
    @(negedge clk); pcwe = 0; ra = 4'd15;
    #1 chk("R6 offset wraps", rda, 32'h4);
  endtask

  task automatic t_ubank;
    logic [31:0] v;
    gw(M_SVC, 1, 4'd13, 32'h5513);
    rd(M_USR, 0, 4'd13, v); chk("R8 user r13 via select", v, 32'h5513);
    rd(M_SVC, 0, 4'd13, v); chk("R8 svc r13 kept", v, 32'h1301);
    rd(M_FIQ, 1, 4'd9, v);  chk("R8 fiq reads user r9", v, 32'h109);
  endtask

  task automatic t_spsr;
    logic [4:0] ms[5] = '{M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND};
    for (int k = 0; k < 5; k++) sw(ms[k], 32'h5000 + k);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); mode = ms[k]; #1 chk("R9 spsr private", spsr, 32'h5000 + k);
    end
    sw(M_USR, 32'hDEAD);
    sw(M_SYS, 32'hBEEF);
    #1 chk("R9 system spsr zero", spsr, 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); mode = ms[k]; #1 chk("R9 spsr after ignored writes", spsr, 32'h5000 + k);
    end
  endtask

  task automatic t_cpsr;
    @(negedge clk); cwd = 32'h6000_00D3; cwe = 1;
    @(negedge clk); cwe = 0;
    #1 chk("R10 cpsr", cpsr, 32'h6000_00D3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual %h expected %h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_ni = 1;
    t_reset;
    t_user_sys;
    t_fiq;
    t_short;
    t_ports;
    t_pc;
    t_ubank;
    t_spsr;
    t_cpsr;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule